// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block holds one byte of completion status for every frame that the transmit engine finishes. The engine presents four outcome flags together with a push strobe. The host sees the oldest unread entry on a status byte. Any host write to that status location removes the entry on view and brings the next one forward.

When the engine finishes more frames than the storage can hold, the surplus status is dropped. The loss is flagged inside the status byte currently on view. A registered completion event goes to the interrupt logic whenever a pushed frame asked for an interrupt or ended in an error. A transmit reset input flushes all stored status.

Top module: `txdone_stack`

## Requirements
- R1: Entries are presented oldest-first. The depth is the parameter DEPTH (default 4), so DEPTH pushes are all held and read back in push order.
- R2: A host write (`host_wr` high for one cycle) removes the entry on view. A host write while the store is empty has no effect.
- R3: Status byte layout when an entry is on view: bit 7 = 1 (valid). Bits 6..3 are the pushed flags: bit 6 interrupt-on-success requested (`push_flags[3]`), bit 5 jabber (`push_flags[2]`), bit 4 underrun (`push_flags[1]`), bit 3 maximum collisions (`push_flags[0]`). Bit 2 is overflow. Bits 1..0 are always 0.
- R4: With no entry stored, `rd_status` reads 8'h00.
- R5: A push into a full store, with no removal in the same cycle, discards the new entry and sets bit 2 of the entry on view. Bit 2 clears when that entry is removed.
- R6: When a push and a host write fall in the same cycle, both take effect. On a full store the push is kept and no overflow is flagged. On an empty store the push is kept and the write does nothing.
- R7: `txc_evt` is high for exactly the cycle after any push whose flags are not all zero, whether or not the entry was kept. It is low after a push with all flags zero and after idle cycles.
- R8: `txreset` empties the store, clears overflow and clears `txc_evt`. It overrides a push or host write in the same cycle.
- R9: After `rst_n` is released, `rd_status` is 8'h00 and `txc_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Engine pushes one completion entry |
| push_flags | input | 4 | {intreq, jabber, underrun, maxcoll} of the finished frame |
| host_wr | input | 1 | Host write to the status location; removes the entry on view |
| txreset | input | 1 | Synchronous transmit reset; flushes the store |
| rd_status | output | 8 | Status byte of the entry on view |
| txc_evt | output | 1 | Transmit-complete event toward the interrupt logic |

## Verification
A push and a host write can fall in the same clock cycle. On a full store this decides whether overflow is flagged or the new entry is accepted. On an empty store it decides whether the write is ignored while the push is kept. The bench drives both strobes together in both states, and also while overflow is already set. A queue-based reference model predicts the resulting status byte, which is compared one cycle later.

// File: rtl/txdone_stack.sv
module txdone_stack #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [3:0] push_flags,
  input  logic       host_wr,
  input  logic       txreset,
  output logic [7:0] rd_status,
  output logic       txc_evt
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL = (PW+1)'(DEPTH);

  logic [3:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   cnt;
  logic          ovf;

  wire do_pop  = host_wr && (cnt != '0);
  wire do_push = push_valid && ((cnt != FULL) || do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
      txc_evt <= 1'b0;
    end else if (txreset) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      ovf     <= 1'b0;
      txc_evt <= 1'b0;
    end else begin
      txc_evt <= push_valid && (push_flags != 4'h0);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_push && !do_pop) cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (do_pop) ovf <= 1'b0;
      else if (push_valid && !do_push) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !txreset) mem[wr_ptr] <= push_flags;
  end

  assign rd_status = (cnt == '0) ? 8'h00 : {1'b1, mem[rd_ptr], ovf, 2'b00};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R1
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_status[7] && !push_valid && !txreset) |=> (rd_status == 8'h00)); // R2
  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && push_valid && !host_wr && !txreset) |=> rd_status[2]); // R5
  AST_FULL_SWAP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && push_valid && host_wr && !txreset) |=> (!rd_status[2] && cnt == FULL)); // R6
  AST_EVT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_flags != 4'h0 && !txreset) |=> txc_evt); // R7
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    txreset |=> (rd_status == 8'h00 && !txc_evt)); // R8
endmodule

// File: tb/txdone_stack_test.sv
module txdone_stack_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic [3:0] push_flags = 4'h0;
  logic       host_wr = 1'b0;
  logic       txreset = 1'b0;
  logic [7:0] rd_status;
  logic       txc_evt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] model_q[$];
  bit         model_ovf = 1'b0;
  bit         exp_evt = 1'b0;

  txdone_stack #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_flags(push_flags),
    .host_wr(host_wr), .txreset(txreset), .rd_status(rd_status), .txc_evt(txc_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_status();
    if (model_q.size() == 0) return 8'h00;
    return {1'b1, model_q[0], model_ovf, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic model_update(input bit p, input logic [3:0] f, input bit w, input bit r);
    bit full, popped;
    if (r) begin
      model_q.delete();
      model_ovf = 1'b0;
      exp_evt = 1'b0;
      return;
    end
    exp_evt = p && (f != 4'h0);
    full = (model_q.size() == DEPTH);
    popped = w && (model_q.size() != 0);
    if (popped) begin
      void'(model_q.pop_front());
      model_ovf = 1'b0;
    end
    if (p) begin
      if (full && !popped) model_ovf = 1'b1;
      else model_q.push_back(f);
    end
  endtask

  task automatic step(input string req, input bit p, input logic [3:0] f, input bit w, input bit r);
    push_valid = p; push_flags = f; host_wr = w; txreset = r;
    @(posedge clk);
    model_update(p, f, w, r);
    @(negedge clk);
    push_valid = 1'b0; push_flags = 4'h0; host_wr = 1'b0; txreset = 1'b0;
    check(req, rd_status, exp_status());
    check({req, " evt"}, {7'h0, txc_evt}, {7'h0, exp_evt});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset status", rd_status, 8'h00);
    check("R9 reset evt", {7'h0, txc_evt}, 8'h00);

    step("R2 R4 pop empty", 0, 4'h0, 1, 0);
    step("R1 R3 R7 push intreq", 1, 4'h8, 0, 0);
    check("R3 byte intreq", rd_status, 8'hC0);
    step("R1 push jabber", 1, 4'h4, 0, 0);
    step("R1 push maxcoll", 1, 4'h1, 0, 0);
    step("R7 push no flags", 1, 4'h0, 0, 0);
    step("R5 push full", 1, 4'hF, 0, 0);
    check("R5 ovf on view", rd_status, 8'hC4);
    step("R5 R1 pop clears ovf", 0, 4'h0, 1, 0);
    check("R1 second entry", rd_status, 8'hA0);
    step("R6 fill", 1, 4'h2, 0, 0);
    step("R6 full push+pop", 1, 4'h6, 1, 0);
    step("R5 overflow again", 1, 4'h0, 0, 0);
    step("R6 swap with ovf set", 1, 4'h3, 1, 0);
    for (int i = 0; i < DEPTH; i++) step("R1 drain", 0, 4'h0, 1, 0);
    check("R4 drained", rd_status, 8'h00);
    step("R2 pop empty again", 0, 4'h0, 1, 0);
    step("R6 empty push+pop", 1, 4'h9, 1, 0);
    step("R3 push all", 1, 4'hF, 0, 0);
    step("R8 reset with push", 1, 4'hF, 1, 1);
    check("R8 flushed", rd_status, 8'h00);
    step("R8 push after reset", 1, 4'h2, 0, 0);
    step("R7 idle evt low", 0, 4'h0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule